// File: doc/BRIEF.md
# Control Transfer Resolution Unit

This block settles the outcome of a control-transfer instruction in an integer core. For one request it takes the current program counter, the instruction length, the two source operands, a sign-extended immediate, the kind of transfer, a comparison code, a 32-bit mode flag and a flag that says whether 16-bit instructions are allowed. One clock edge later it presents the taken decision, the next fetch address, the link value with its destination, and, when the target is not properly aligned, an address-misaligned exception carrying the faulting target.

The unit is purely a per-request computation with one register stage. Fetch, register file writeback and trap vectoring sit around it and consume its single response strobe. When an exception is raised it wins over the redirect, and the trapping instruction writes no register.

Top module: `ctl_xfer_unit`

## Requirements
- R1: A request with `req_valid`=1 produces exactly one response with `rsp_valid`=1 on the next rising clock edge. Whenever `rsp_valid`=0, including after reset, every other output is zero.
- R2: For kind code 0 (direct jump) the transfer is taken and, without an exception, `rsp_redirect`=1 and `rsp_next_pc` = PC + immediate.
- R3: For kind code 1 (register jump) the target is operand A + immediate with bit 0 forced to zero.
- R4: With `req_mode32`=1, the jump target, the branch target, the fall-through address and the link value are sign-extended from bit 31, and branch operands are compared as their low 32 bits sign-extended from bit 31.
- R5: The link value is PC + 4 when `req_len4`=1 and PC + 2 when it is 0; `rsp_link_we`=1 only for kinds 0 and 1 without an exception. Kind 2 (conditional branch) never writes a register.
- R6: A link write to register index 0 is dropped: `rsp_link_we`=0 and `rsp_link_rd`=0.
- R7: For kind 2 the comparison code selects: 000 equal, 001 not equal, 100 signed less-than, 101 signed greater-or-equal, 110 unsigned less-than, 111 unsigned greater-or-equal; codes 010 and 011 are never taken.
- R8: A not-taken branch, and any request of kind code 3 (no transfer), gives `rsp_taken`=0, `rsp_redirect`=0, `rsp_excp`=0 and `rsp_next_pc` = PC + instruction length.
- R9: For kinds 0 and 1 with `req_rvc_en`=0, a target with bit 1 set gives `rsp_excp`=1, `rsp_excp_addr` = target, `rsp_redirect`=0, `rsp_next_pc`=0 and no link write.
- R10: For a taken branch with `req_rvc_en`=0, a nonzero value in immediate bits 1:0 gives `rsp_excp`=1 with `rsp_excp_addr` = PC + immediate instead of a redirect.
- R11: With `req_rvc_en`=1 no request raises an exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | 0 direct jump, 1 register jump, 2 conditional branch, 3 no transfer |
| req_cond | input | 3 | Branch comparison code |
| req_pc | input | XLEN | Current program counter |
| req_len4 | input | 1 | 1: 4-byte instruction, 0: 2-byte instruction |
| req_opa | input | XLEN | First source operand (jump base / compare left) |
| req_opb | input | XLEN | Second source operand (compare right) |
| req_imm | input | XLEN | Sign-extended immediate |
| req_rd | input | 5 | Link destination register index |
| req_mode32 | input | 1 | 1: 32-bit address and compare mode |
| req_rvc_en | input | 1 | 1: 16-bit instructions allowed |
| rsp_valid | output | 1 | Response strobe |
| rsp_taken | output | 1 | Transfer taken |
| rsp_redirect | output | 1 | Fetch must continue at rsp_next_pc out of sequence |
| rsp_next_pc | output | XLEN | Next fetch address (zero on exception) |
| rsp_link_we | output | 1 | Link register write enable |
| rsp_link_rd | output | 5 | Link register index |
| rsp_link_val | output | XLEN | Link value |
| rsp_excp | output | 1 | Instruction-address-misaligned exception |
| rsp_excp_addr | output | XLEN | Faulting target address |

## Verification
The bench aims at the borders where a wrong design diverges: a register-jump sum with bit 0 set, which a design that forgot the mask would redirect to an odd address; a 32-bit sum that crosses bit 31, which a design without sign extension would leave as a positive 64-bit target; and operand pairs that order differently signed and unsigned, which a design with swapped comparison codes would decide wrongly. It also drives targets with bit 1 set under both settings of the 16-bit flag, a taken and a not-taken branch with an unaligned immediate, and jumps to register 0, where a faulty design would trap when it must not, redirect where it must trap, or write a register that must stay untouched.

// File: rtl/ctl_xfer_pkg.sv
package ctl_xfer_pkg;

    localparam int REG_IDX_W = 5;

    typedef enum logic [1:0] {
        KIND_JAL  = 2'd0,
        KIND_JALR = 2'd1,
        KIND_BR   = 2'd2,
        KIND_NONE = 2'd3
    } xfer_kind_e;

    localparam logic [2:0] CMP_EQ  = 3'b000;
    localparam logic [2:0] CMP_NE  = 3'b001;
    localparam logic [2:0] CMP_LT  = 3'b100;
    localparam logic [2:0] CMP_GE  = 3'b101;
    localparam logic [2:0] CMP_LTU = 3'b110;
    localparam logic [2:0] CMP_GEU = 3'b111;

endpackage

// File: rtl/ctl_xfer_addr.sv
// Address adder: base + offset, optional bit-0 clear, optional 32-bit sign extension.
module ctl_xfer_addr #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] base_i,
    input  logic [XLEN-1:0] off_i,
    input  logic            clr_lsb_i,
    input  logic            mode32_i,
    output logic [XLEN-1:0] sum_o
);
    logic [XLEN-1:0] raw;
    logic [XLEN-1:0] masked;

    assign raw    = base_i + off_i;
    assign masked = {raw[XLEN-1:1], raw[0] & ~clr_lsb_i};

    generate
        if (XLEN > 32) begin : g_wide
            localparam int EXT_W = XLEN - 32;
            assign sum_o = mode32_i ? {{EXT_W{masked[31]}}, masked[31:0]} : masked;
        end else begin : g_narrow
            logic unused_mode;
            assign unused_mode = mode32_i;
            assign sum_o = masked;
        end
    endgenerate
endmodule

// File: rtl/ctl_xfer_cmp.sv
// Branch condition evaluator.
module ctl_xfer_cmp
    import ctl_xfer_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] opa_i,
    input  logic [XLEN-1:0] opb_i,
    input  logic [2:0]      cond_i,
    input  logic            mode32_i,
    output logic            take_o
);
    logic [XLEN-1:0] a_x;
    logic [XLEN-1:0] b_x;
    logic            is_eq;
    logic            is_lts;
    logic            is_ltu;

    generate
        if (XLEN > 32) begin : g_wide
            localparam int EXT_W = XLEN - 32;
            assign a_x = mode32_i ? {{EXT_W{opa_i[31]}}, opa_i[31:0]} : opa_i;
            assign b_x = mode32_i ? {{EXT_W{opb_i[31]}}, opb_i[31:0]} : opb_i;
        end else begin : g_narrow
            logic unused_mode;
            assign unused_mode = mode32_i;
            assign a_x = opa_i;
            assign b_x = opb_i;
        end
    endgenerate

    assign is_eq  = (a_x == b_x);
    assign is_lts = ($signed(a_x) < $signed(b_x));
    assign is_ltu = (a_x < b_x);

    always_comb begin
        unique case (cond_i)
            CMP_EQ:  take_o = is_eq;
            CMP_NE:  take_o = ~is_eq;
            CMP_LT:  take_o = is_lts;
            CMP_GE:  take_o = ~is_lts;
            CMP_LTU: take_o = is_ltu;
            CMP_GEU: take_o = ~is_ltu;
            default: take_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/ctl_xfer_unit.sv
module ctl_xfer_unit
    import ctl_xfer_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [1:0]           req_kind,
    input  logic [2:0]           req_cond,
    input  logic [XLEN-1:0]      req_pc,
    input  logic                 req_len4,
    input  logic [XLEN-1:0]      req_opa,
    input  logic [XLEN-1:0]      req_opb,
    input  logic [XLEN-1:0]      req_imm,
    input  logic [REG_IDX_W-1:0] req_rd,
    input  logic                 req_mode32,
    input  logic                 req_rvc_en,
    output logic                 rsp_valid,
    output logic                 rsp_taken,
    output logic                 rsp_redirect,
    output logic [XLEN-1:0]      rsp_next_pc,
    output logic                 rsp_link_we,
    output logic [REG_IDX_W-1:0] rsp_link_rd,
    output logic [XLEN-1:0]      rsp_link_val,
    output logic                 rsp_excp,
    output logic [XLEN-1:0]      rsp_excp_addr
);
    localparam logic [XLEN-1:0] STEP_WORD = XLEN'(4);
    localparam logic [XLEN-1:0] STEP_HALF = XLEN'(2);

    typedef struct packed {
        logic                 valid;
        logic                 taken;
        logic                 redirect;
        logic                 excp;
        logic                 link_we;
        logic [REG_IDX_W-1:0] link_rd;
        logic [XLEN-1:0]      next_pc;
        logic [XLEN-1:0]      link_val;
        logic [XLEN-1:0]      excp_addr;
    } rsp_t;

    rsp_t rsp_d;
    rsp_t rsp_q;

    xfer_kind_e      kind;
    logic            is_jalr;
    logic [XLEN-1:0] tgt_base;
    logic [XLEN-1:0] tgt_addr;
    logic [XLEN-1:0] step;
    logic [XLEN-1:0] fall_addr;
    logic            br_take;

    assign kind     = xfer_kind_e'(req_kind);
    assign is_jalr  = (kind == KIND_JALR);
    assign tgt_base = is_jalr ? req_opa : req_pc;
    assign step     = req_len4 ? STEP_WORD : STEP_HALF;

    ctl_xfer_addr #(.XLEN(XLEN)) u_tgt (
        .base_i    (tgt_base),
        .off_i     (req_imm),
        .clr_lsb_i (is_jalr),
        .mode32_i  (req_mode32),
        .sum_o     (tgt_addr)
    );

    ctl_xfer_addr #(.XLEN(XLEN)) u_fall (
        .base_i    (req_pc),
        .off_i     (step),
        .clr_lsb_i (1'b0),
        .mode32_i  (req_mode32),
        .sum_o     (fall_addr)
    );

    ctl_xfer_cmp #(.XLEN(XLEN)) u_cmp (
        .opa_i    (req_opa),
        .opb_i    (req_opb),
        .cond_i   (req_cond),
        .mode32_i (req_mode32),
        .take_o   (br_take)
    );

    always_comb begin
        logic misal;
        rsp_d = '0;
        misal = 1'b0;
        if (req_valid) begin
            rsp_d.valid = 1'b1;
            unique case (kind)
                KIND_JAL, KIND_JALR: begin
                    misal          = ~req_rvc_en & tgt_addr[1];
                    rsp_d.taken    = 1'b1;
                    rsp_d.link_val = fall_addr;
                    if (misal) begin
                        rsp_d.excp      = 1'b1;
                        rsp_d.excp_addr = tgt_addr;
                    end else begin
                        rsp_d.redirect = 1'b1;
                        rsp_d.next_pc  = tgt_addr;
                        if (req_rd != '0) begin
                            rsp_d.link_we = 1'b1;
                            rsp_d.link_rd = req_rd;
                        end
                    end
                end
                KIND_BR: begin
                    if (br_take) begin
                        misal       = ~req_rvc_en & (req_imm[1:0] != 2'b00);
                        rsp_d.taken = 1'b1;
                        if (misal) begin
                            rsp_d.excp      = 1'b1;
                            rsp_d.excp_addr = tgt_addr;
                        end else begin
                            rsp_d.redirect = 1'b1;
                            rsp_d.next_pc  = tgt_addr;
                        end
                    end else begin
                        rsp_d.next_pc = fall_addr;
                    end
                end
                default: begin
                    rsp_d.next_pc = fall_addr;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid     = rsp_q.valid;
    assign rsp_taken     = rsp_q.taken;
    assign rsp_redirect  = rsp_q.redirect;
    assign rsp_next_pc   = rsp_q.next_pc;
    assign rsp_link_we   = rsp_q.link_we;
    assign rsp_link_rd   = rsp_q.link_rd;
    assign rsp_link_val  = rsp_q.link_val;
    assign rsp_excp      = rsp_q.excp;
    assign rsp_excp_addr = rsp_q.excp_addr;
endmodule

// File: rtl/ctl_xfer_chk.sv
module ctl_xfer_chk
    import ctl_xfer_pkg::*;
#(
    parameter int XLEN = 64
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic [1:0]           req_kind,
    input logic [XLEN-1:0]      req_pc,
    input logic                 req_len4,
    input logic                 req_mode32,
    input logic                 req_rvc_en,
    input logic                 rsp_valid,
    input logic                 rsp_taken,
    input logic                 rsp_redirect,
    input logic [XLEN-1:0]      rsp_next_pc,
    input logic                 rsp_link_we,
    input logic [REG_IDX_W-1:0] rsp_link_rd,
    input logic [XLEN-1:0]      rsp_link_val,
    input logic                 rsp_excp
);
    assert_resp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_noresp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_taken && !rsp_redirect && !rsp_excp && !rsp_link_we));

    assert_jalr_even_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd1) |=> (!rsp_redirect || !rsp_next_pc[0]));

    assert_link_val_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_mode32 && req_kind[1] == 1'b0) |=>
        (rsp_link_val == $past(req_pc) + ($past(req_len4) ? XLEN'(4) : XLEN'(2))));

    assert_branch_nolink_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd2) |=> !rsp_link_we);

    assert_rd_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_link_we |-> (rsp_link_rd != '0));

    assert_not_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_taken) |-> (!rsp_excp && !rsp_redirect));

    assert_excp_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_excp |-> (!rsp_redirect && rsp_next_pc == '0 && !rsp_link_we));

    assert_rvc_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_rvc_en) |=> !rsp_excp);
endmodule

bind ctl_xfer_unit ctl_xfer_chk #(.XLEN(XLEN)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_kind     (req_kind),
    .req_pc       (req_pc),
    .req_len4     (req_len4),
    .req_mode32   (req_mode32),
    .req_rvc_en   (req_rvc_en),
    .rsp_valid    (rsp_valid),
    .rsp_taken    (rsp_taken),
    .rsp_redirect (rsp_redirect),
    .rsp_next_pc  (rsp_next_pc),
    .rsp_link_we  (rsp_link_we),
    .rsp_link_rd  (rsp_link_rd),
    .rsp_link_val (rsp_link_val),
    .rsp_excp     (rsp_excp)
);

// File: tb/ctl_xfer_unit_tb_top.sv
`timescale 1ns/1ps
module ctl_xfer_unit_tb_top;
    localparam int XL = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_kind = 2'd0;
    logic [2:0]    req_cond = 3'd0;
    logic [XL-1:0] req_pc = '0;
    logic          req_len4 = 1'b0;
    logic [XL-1:0] req_opa = '0;
    logic [XL-1:0] req_opb = '0;
    logic [XL-1:0] req_imm = '0;
    logic [4:0]    req_rd = '0;
    logic          req_mode32 = 1'b0;
    logic          req_rvc_en = 1'b0;

    logic          rsp_valid, rsp_taken, rsp_redirect, rsp_link_we, rsp_excp;
    logic [XL-1:0] rsp_next_pc, rsp_link_val, rsp_excp_addr;
    logic [4:0]    rsp_link_rd;

    always #10 clk = ~clk;

    ctl_xfer_unit #(.XLEN(XL)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_cond(req_cond), .req_pc(req_pc), .req_len4(req_len4),
        .req_opa(req_opa), .req_opb(req_opb), .req_imm(req_imm), .req_rd(req_rd),
        .req_mode32(req_mode32), .req_rvc_en(req_rvc_en),
        .rsp_valid(rsp_valid), .rsp_taken(rsp_taken), .rsp_redirect(rsp_redirect),
        .rsp_next_pc(rsp_next_pc), .rsp_link_we(rsp_link_we), .rsp_link_rd(rsp_link_rd),
        .rsp_link_val(rsp_link_val), .rsp_excp(rsp_excp), .rsp_excp_addr(rsp_excp_addr)
    );

    typedef struct {
        logic          taken;
        logic          redirect;
        logic          excp;
        logic          we;
        logic [4:0]    rd;
        logic [XL-1:0] npc;
        logic [XL-1:0] lval;
        logic [XL-1:0] eaddr;
        string         tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;

    function automatic logic [XL-1:0] wrap32(input logic m32, input logic [XL-1:0] v);
        return m32 ? {{32{v[31]}}, v[31:0]} : v;
    endfunction

    function automatic exp_t predict(input logic [1:0] k, input logic [2:0] c,
        input logic [XL-1:0] pc, input logic l4, input logic [XL-1:0] a,
        input logic [XL-1:0] b, input logic [XL-1:0] imm, input logic [4:0] rd,
        input logic m32, input logic rvc, input string tag);
        exp_t e;
        logic [XL-1:0] seq, dst, ca, cb;
        logic go, bad;
        e.taken = 0; e.redirect = 0; e.excp = 0; e.we = 0; e.rd = 0;
        e.npc = 0; e.lval = 0; e.eaddr = 0; e.tag = tag;
        seq = wrap32(m32, pc + (l4 ? 64'd4 : 64'd2));
        if (k == 2'd1) dst = wrap32(m32, (a + imm) & ~64'd1);
        else           dst = wrap32(m32, pc + imm);
        ca = wrap32(m32, a);
        cb = wrap32(m32, b);
        case (c)
            3'b000: go = (ca == cb);
            3'b001: go = (ca != cb);
            3'b100: go = ($signed(ca) < $signed(cb));
            3'b101: go = !($signed(ca) < $signed(cb));
            3'b110: go = (ca < cb);
            3'b111: go = !(ca < cb);
            default: go = 0;
        endcase
        if (k == 2'd0 || k == 2'd1) begin
            e.taken = 1; e.lval = seq;
            bad = !rvc && dst[1];
            if (bad) begin e.excp = 1; e.eaddr = dst; end
            else begin
                e.redirect = 1; e.npc = dst;
                if (rd != 0) begin e.we = 1; e.rd = rd; end
            end
        end else if (k == 2'd2 && go) begin
            e.taken = 1;
            bad = !rvc && (imm[1:0] != 0);
            if (bad) begin e.excp = 1; e.eaddr = dst; end
            else begin e.redirect = 1; e.npc = dst; end
        end else begin
            e.npc = seq;
        end
        return e;
    endfunction

    task automatic issue(input logic [1:0] k, input logic [2:0] c,
        input logic [XL-1:0] pc, input logic l4, input logic [XL-1:0] a,
        input logic [XL-1:0] b, input logic [XL-1:0] imm, input logic [4:0] rd,
        input logic m32, input logic rvc, input string tag);
        @(negedge clk);
        req_valid = 1; req_kind = k; req_cond = c; req_pc = pc; req_len4 = l4;
        req_opa = a; req_opb = b; req_imm = imm; req_rd = rd;
        req_mode32 = m32; req_rvc_en = rvc;
        exp_q.push_back(predict(k, c, pc, l4, a, b, imm, rd, m32, rvc, tag));
    endtask

    task automatic pause(input int n);
        @(negedge clk);
        req_valid = 0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compares every response and the idle state at the falling edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (rsp_valid) begin
                n_checks++;
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R1 unexpected response actual valid=1 expected valid=0");
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (rsp_taken !== e.taken || rsp_redirect !== e.redirect ||
                        rsp_excp !== e.excp || rsp_link_we !== e.we ||
                        rsp_link_rd !== e.rd || rsp_next_pc !== e.npc ||
                        rsp_link_val !== e.lval || rsp_excp_addr !== e.eaddr) begin
                        n_fail++;
                        $display("FAIL %s actual t=%b r=%b x=%b we=%b rd=%0d npc=%h lv=%h ea=%h expected t=%b r=%b x=%b we=%b rd=%0d npc=%h lv=%h ea=%h",
                            e.tag, rsp_taken, rsp_redirect, rsp_excp, rsp_link_we, rsp_link_rd,
                            rsp_next_pc, rsp_link_val, rsp_excp_addr,
                            e.taken, e.redirect, e.excp, e.we, e.rd, e.npc, e.lval, e.eaddr);
                    end
                end
            end else if (exp_q.size() != 0 && req_valid == 1'b0) begin
                n_checks++;
                n_fail++;
                $display("FAIL R1 missing response actual valid=0 expected valid=1 (%s)", exp_q[0].tag);
                void'(exp_q.pop_front());
            end
        end
    end

    task automatic check_idle(input string tag);
        n_checks++;
        if (rsp_valid !== 0 || rsp_taken !== 0 || rsp_redirect !== 0 || rsp_excp !== 0 ||
            rsp_link_we !== 0 || rsp_link_rd !== 0 || rsp_next_pc !== 0 ||
            rsp_link_val !== 0 || rsp_excp_addr !== 0) begin
            n_fail++;
            $display("FAIL %s idle outputs actual v=%b npc=%h lv=%h ea=%h expected all zero",
                tag, rsp_valid, rsp_next_pc, rsp_link_val, rsp_excp_addr);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual running expected done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check_idle("R1 reset");
        rst_n = 1;
        @(negedge clk);
        check_idle("R1 after reset");

        // R2 direct jumps, forward and backward, R5 link with both lengths
        issue(2'd0, 3'd0, 64'h1000, 1, 0, 0, 64'h0000_0000_0000_0100, 5'd1, 0, 0, "R2 jal fwd R5");
        issue(2'd0, 3'd0, 64'h1000, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FF00, 5'd5, 0, 1, "R2 jal back R5 len2");
        // R3 register jump with odd sum; R6 destination zero
        issue(2'd1, 3'd0, 64'h2000, 1, 64'h0000_0000_0000_4001, 0, 64'd8, 5'd3, 0, 0, "R3 jalr odd");
        issue(2'd1, 3'd0, 64'h2000, 1, 64'h0000_0000_0000_4000, 0, 64'd5, 5'd0, 0, 0, "R6 jalr rd0");
        // R4 32-bit mode crossing bit 31
        issue(2'd1, 3'd0, 64'h7FFF_FFFE, 1, 64'h7FFF_FFF0, 0, 64'h20, 5'd9, 1, 0, "R4 jalr wrap32");
        issue(2'd2, 3'b100, 64'h100, 1, 64'h0000_0000_8000_0000, 64'd0, 64'h40, 5'd0, 1, 0, "R4 blt m32");
        issue(2'd2, 3'b100, 64'h100, 1, 64'h0000_0000_8000_0000, 64'd0, 64'h40, 5'd0, 0, 0, "R4 blt m64 R8");
        pause(2);
        check_idle("R1 gap");

        // R7 all comparison codes, signed/unsigned split operands
        for (int c = 0; c < 8; c++) begin
            issue(2'd2, 3'(c), 64'h3000, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 64'h10, 5'd4, 0, 0, "R7 cond neg-vs-one");
            issue(2'd2, 3'(c), 64'h3000, 0, 64'd77, 64'd77, 64'hFFFF_FFFF_FFFF_FFF0, 5'd4, 0, 1, "R7 cond equal");
        end
        // R8 no-transfer kind
        issue(2'd3, 3'b000, 64'h5000, 1, 0, 0, 64'h80, 5'd7, 0, 0, "R8 kind none");
        // R9 jump targets with bit 1 set, R11 flag on
        issue(2'd1, 3'd0, 64'h6000, 1, 64'h8000, 0, 64'd2, 5'd2, 0, 0, "R9 jalr misaligned");
        issue(2'd0, 3'd0, 64'h6000, 1, 0, 0, 64'd6, 5'd2, 0, 0, "R9 jal misaligned");
        issue(2'd1, 3'd0, 64'h6000, 1, 64'h8000, 0, 64'd2, 5'd2, 0, 1, "R11 jalr rvc");
        // R10 unaligned branch immediate
        issue(2'd2, 3'b000, 64'h7000, 1, 64'd3, 64'd3, 64'd6, 5'd0, 0, 0, "R10 beq taken misal");
        issue(2'd2, 3'b001, 64'h7000, 1, 64'd3, 64'd3, 64'd6, 5'd0, 0, 0, "R8 bne not taken misal");
        issue(2'd2, 3'b000, 64'h7000, 0, 64'd3, 64'd3, 64'd6, 5'd0, 0, 1, "R11 beq rvc");
        issue(2'd2, 3'b110, 64'h7000, 1, 64'd1, 64'd2, 64'hFFFF_FFFF_FFFF_FFFD, 5'd0, 1, 0, "R10 bltu odd imm");
        pause(3);
        check_idle("R1 end idle");

        n_checks++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R1 pending responses actual=%0d expected=0", exp_q.size());
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule